// File: doc/BRIEF.md
# Page Access Permission Checker

This block decides whether one memory access from a core may go ahead. It sits between address generation and the memory interface. Each cycle it can take one access: a 32-bit address, an access kind (instruction fetch, data read or data write), the privilege of the running code, a flag that says whether the address space is virtual or physical, and the execute, write and read enable bits from the page table entry that translated the address.

Two independent checks run on every access. The first is a privilege-region check that applies only to the least privileged level, User-0. The second is a page permission check that applies only to accesses marked as page-table translated. A clean access is granted combinationally in the same cycle. An offending access raises exactly one trap pulse, one cycle later. The region trap outranks the page trap.

Top module: `page_access_checker`

## Requirements
- R1: A translated (`xlat_pte`=1) instruction fetch (`acc_kind`=2'b00) is denied with a page trap when `pte_exec` is 0, and is granted when `pte_exec` is 1 and no region rule is broken.
- R2: A translated data write (`acc_kind`=2'b10) is denied with a page trap when `pte_wr` is 0.
- R3: A translated data read (`acc_kind`=2'b01, and code 2'b11, which is also handled as a read) is denied with a page trap when `pte_rd` is 0.
- R4: In virtual mode (`virt_mode`=1), a User-0 access (`priv`=2'b00) to any address with bit 31 set raises the region trap.
- R5: In physical mode (`virt_mode`=0), a User-0 access raises the region trap only when the segment number (address bits [31:28]) is 14 or 15. Segment 13 and all lower segments are allowed.
- R6: User-1 (`priv`=2'b01), Supervisor (2'b10) and code 2'b11 (handled as Supervisor) never raise the region trap.
- R7: When `xlat_pte` is 0, the page enable bits have no effect on grant or traps.
- R8: When an access breaks both rules, only `trap_region` pulses and `trap_page` stays low.
- R9: `acc_grant` is high in the same cycle exactly for a valid access that breaks no rule. A trap output pulses high for exactly the one cycle after the offending access's clock edge. No trap follows a granted access or a cycle without `acc_valid`.
- R10: While `rst_n` is low, and after the first clock edge of reset, both trap outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | 32 | Access address |
| acc_kind | input | 2 | 00 fetch, 01 read, 10 write, 11 read |
| priv | input | 2 | 00 User-0, 01 User-1, 10/11 Supervisor |
| virt_mode | input | 1 | 1 virtual address space, 0 physical |
| xlat_pte | input | 1 | Access was translated through a page table entry |
| pte_exec | input | 1 | Page allows instruction fetch |
| pte_wr | input | 1 | Page allows data write |
| pte_rd | input | 1 | Page allows data read |
| acc_grant | output | 1 | Access allowed (combinational) |
| trap_region | output | 1 | Registered privilege-region trap pulse |
| trap_page | output | 1 | Registered page permission trap pulse |

## Verification
The bench builds the checker with its default parameters: a 32-bit address, a 4-bit segment field and two blocked top segments in physical mode. With these values the segment boundary between 13 and 14 and the bit-31 split of the virtual space are the ones the requirements name, so directed cases can land on both sides of each. Random addresses are drawn with a bias toward the top segments so that region hits and misses happen often in both modes. Privilege code 11 and access code 11 both come up in the random mix.

// File: rtl/pac_pkg.sv
// Shared encodings for the page access checker.
// Assumes a 2-bit privilege and a 2-bit access-kind code on the ports.
package pac_pkg;
    typedef enum logic [1:0] {
        PRIV_U0  = 2'b00,
        PRIV_U1  = 2'b01,
        PRIV_SV  = 2'b10,
        PRIV_SV2 = 2'b11
    } priv_e;

    typedef enum logic [1:0] {
        KIND_FETCH = 2'b00,
        KIND_READ  = 2'b01,
        KIND_WRITE = 2'b10,
        KIND_READ2 = 2'b11
    } kind_e;

    typedef struct packed {
        logic exec;
        logic wr;
        logic rd;
    } pte_perm_t;
endpackage

// File: rtl/pac_region_check.sv
// Privilege-region rule: flags a User-0 access into the restricted part
// of the address space. In virtual mode that is the upper half (top
// address bit). In physical mode it is the top PHYS_TOP_SEGS segments.
// Assumes 0 < PHYS_TOP_SEGS <= 2**SEG_W.
module pac_region_check #(
    parameter int unsigned ADDR_W        = 32,
    parameter int unsigned SEG_W         = 4,
    parameter int unsigned PHYS_TOP_SEGS = 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        priv,
    input  logic              virt_mode,
    output logic              region_hit
);
    import pac_pkg::*;

    localparam int unsigned SEG_COUNT = 1 << SEG_W;
    localparam int unsigned SEG_FIRST = SEG_COUNT - PHYS_TOP_SEGS;

    logic [SEG_W-1:0] seg;
    logic             is_user0;
    logic             upper_half;
    logic             top_segs;

    // Decode the segment, the half of the space and the privilege.
    always_comb begin
        seg        = addr[ADDR_W-1 -: SEG_W];
        is_user0   = (priv == PRIV_U0);
        upper_half = addr[ADDR_W-1];
        top_segs   = (seg >= SEG_W'(SEG_FIRST));
        region_hit = is_user0 && (virt_mode ? upper_half : top_segs);
    end
endmodule

// File: rtl/pac_page_check.sv
// Page permission rule: picks the enable bit that matches the access
// kind and flags the access when that bit is clear. Only accesses that
// went through page-table translation are checked.
module pac_page_check (
    input  logic               xlat,
    input  logic [1:0]         kind,
    input  pac_pkg::pte_perm_t perm,
    output logic               page_hit
);
    import pac_pkg::*;

    logic allowed;

    // Select the enable bit for this kind of access.
    always_comb begin
        unique case (kind)
            KIND_FETCH: allowed = perm.exec;
            KIND_WRITE: allowed = perm.wr;
            default:    allowed = perm.rd;
        endcase
        page_hit = xlat && !allowed;
    end
endmodule

// File: rtl/pac_trap_reg.sv
// Trap register: turns this cycle's verdicts into one-cycle trap pulses
// on the next cycle. The region trap takes priority, so at most one trap
// pulses per access.
module pac_trap_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic valid,
    input  logic region_hit,
    input  logic page_hit,
    output logic trap_region,
    output logic trap_page
);
    // Register the prioritised trap pulses; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap_region <= 1'b0;
            trap_page   <= 1'b0;
        end else begin
            trap_region <= valid && region_hit;
            trap_page   <= valid && page_hit && !region_hit;
        end
    end
endmodule

// File: rtl/page_access_checker.sv
// Top of the page access checker. It grants a clean access in the same
// cycle and reports a violation as a registered trap pulse one cycle
// later. Assumes at most one access per cycle and that the page enable
// bits are valid whenever xlat_pte is high.
module page_access_checker #(
    parameter int unsigned ADDR_W        = 32,
    parameter int unsigned SEG_W         = 4,
    parameter int unsigned PHYS_TOP_SEGS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_kind,
    input  logic [1:0]        priv,
    input  logic              virt_mode,
    input  logic              xlat_pte,
    input  logic              pte_exec,
    input  logic              pte_wr,
    input  logic              pte_rd,
    output logic              acc_grant,
    output logic              trap_region,
    output logic              trap_page
);
    import pac_pkg::*;

    logic      region_hit;
    logic      page_hit;
    pte_perm_t perm;

    // Bundle the page enable bits.
    always_comb perm = '{exec: pte_exec, wr: pte_wr, rd: pte_rd};

    pac_region_check #(
        .ADDR_W(ADDR_W), .SEG_W(SEG_W), .PHYS_TOP_SEGS(PHYS_TOP_SEGS)
    ) u_region (
        .addr(acc_addr), .priv(priv), .virt_mode(virt_mode),
        .region_hit(region_hit)
    );

    pac_page_check u_page (
        .xlat(xlat_pte), .kind(acc_kind), .perm(perm), .page_hit(page_hit)
    );

    pac_trap_reg u_trap (
        .clk(clk), .rst_n(rst_n), .valid(acc_valid),
        .region_hit(region_hit), .page_hit(page_hit),
        .trap_region(trap_region), .trap_page(trap_page)
    );

    // Grant a valid access that breaks neither rule.
    always_comb acc_grant = acc_valid && !region_hit && !page_hit;
endmodule

// File: rtl/page_access_checker_sva.sv
// Checker for page_access_checker, attached by bind below.
module page_access_checker_sva #(
    parameter int unsigned ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [1:0]        priv,
    input logic              virt_mode,
    input logic              xlat_pte,
    input logic              acc_grant,
    input logic              trap_region,
    input logic              trap_page
);
    assert_one_trap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(trap_region && trap_page));

    assert_region_user0_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trap_region) |-> $past(acc_valid && priv == 2'b00));

    assert_virt_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && priv == 2'b00 && virt_mode && acc_addr[ADDR_W-1]) |=> trap_region);

    assert_page_needs_xlat_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !xlat_pte) |=> !trap_page);

    assert_grant_no_trap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        acc_grant |=> (!trap_region && !trap_page));

    assert_idle_no_trap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> (!trap_region && !trap_page));
endmodule

bind page_access_checker page_access_checker_sva #(.ADDR_W(ADDR_W)) u_sva (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .priv(priv), .virt_mode(virt_mode), .xlat_pte(xlat_pte),
    .acc_grant(acc_grant), .trap_region(trap_region), .trap_page(trap_page)
);

// File: tb/page_access_checker_tb.sv
module page_access_checker_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [1:0]  acc_kind = '0;
    logic [1:0]  priv = '0;
    logic        virt_mode = 1'b0;
    logic        xlat_pte = 1'b0;
    logic        pte_exec = 1'b0;
    logic        pte_wr = 1'b0;
    logic        pte_rd = 1'b0;
    logic        acc_grant, trap_region, trap_page;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    page_access_checker u_dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_kind(acc_kind), .priv(priv), .virt_mode(virt_mode),
        .xlat_pte(xlat_pte), .pte_exec(pte_exec), .pte_wr(pte_wr),
        .pte_rd(pte_rd), .acc_grant(acc_grant), .trap_region(trap_region),
        .trap_page(trap_page)
    );

    // Expected region verdict from R4, R5, R6.
    function automatic bit exp_region(input logic [31:0] a, input logic [1:0] p, input logic vm);
        if (p != 2'b00) return 1'b0;
        if (vm) return a[31];
        return (a[31:28] >= 4'd14);
    endfunction

    // Expected page verdict from R1, R2, R3, R7.
    function automatic bit exp_page(input logic x, input logic [1:0] k,
                                    input logic e, input logic w, input logic r);
        if (!x) return 1'b0;
        case (k)
            2'b00:   return !e;
            2'b10:   return !w;
            default: return !r;
        endcase
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b (addr %h kind %b priv %b vm %b x %b)",
                     req, act, exp, acc_addr, acc_kind, priv, virt_mode, xlat_pte);
        end
    endtask

    // Apply one access, check grant in cycle, traps after the edge.
    task automatic access(input string req, input logic v, input logic [31:0] a,
                          input logic [1:0] k, input logic [1:0] p, input logic vm,
                          input logic x, input logic e, input logic w, input logic r);
        bit rh, ph;
        @(negedge clk);
        acc_valid = v; acc_addr = a; acc_kind = k; priv = p; virt_mode = vm;
        xlat_pte = x; pte_exec = e; pte_wr = w; pte_rd = r;
        rh = v && exp_region(a, p, vm);
        ph = v && exp_page(x, k, e, w, r) && !rh;
        #1;
        check({req, " grant"}, acc_grant, v && !exp_region(a, p, vm) && !exp_page(x, k, e, w, r));
        @(posedge clk); #1;
        check({req, " trap_region"}, trap_region, rh);
        check({req, " trap_page"}, trap_page, ph);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : stim
        int seed = 32'h5EED_1234;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        #1;
        check("R10 reset trap_region", trap_region, 1'b0);
        check("R10 reset trap_page", trap_page, 1'b0);
        @(negedge clk); rst_n = 1'b1;

        // R1 fetch with and without execute enable
        access("R1 fetch no exec", 1, 32'h1000_0000, 2'b00, 2'b10, 1, 1, 0, 1, 1);
        access("R1 fetch exec", 1, 32'h1000_0000, 2'b00, 2'b10, 1, 1, 1, 0, 0);
        // R2 write
        access("R2 write no wr", 1, 32'h2000_0040, 2'b10, 2'b01, 1, 1, 1, 0, 1);
        access("R2 write wr", 1, 32'h2000_0040, 2'b10, 2'b01, 1, 1, 0, 1, 0);
        // R3 read, both codes
        access("R3 read no rd", 1, 32'h0000_0100, 2'b01, 2'b00, 1, 1, 1, 1, 0);
        access("R3 read code11 no rd", 1, 32'h0000_0100, 2'b11, 2'b10, 0, 1, 1, 1, 0);
        // R4 virtual upper half boundary
        access("R4 virt upper", 1, 32'h8000_0000, 2'b01, 2'b00, 1, 0, 0, 0, 0);
        access("R4 virt lower", 1, 32'h7FFF_FFFF, 2'b01, 2'b00, 1, 0, 0, 0, 0);
        // R5 physical segment boundary
        access("R5 phys seg14", 1, 32'hE000_0000, 2'b01, 2'b00, 0, 0, 0, 0, 0);
        access("R5 phys seg15", 1, 32'hFFFF_FFFC, 2'b01, 2'b00, 0, 0, 0, 0, 0);
        access("R5 phys seg13", 1, 32'hDFFF_FFFC, 2'b01, 2'b00, 0, 0, 0, 0, 0);
        access("R5 phys seg8", 1, 32'h8000_0000, 2'b01, 2'b00, 0, 0, 0, 0, 0);
        // R6 higher privileges
        access("R6 user1 top", 1, 32'hF000_0000, 2'b01, 2'b01, 1, 0, 0, 0, 0);
        access("R6 priv11 top", 1, 32'hF000_0000, 2'b01, 2'b11, 0, 0, 0, 0, 0);
        // R7 untranslated ignores enables
        access("R7 no xlat", 1, 32'h1000_0000, 2'b10, 2'b10, 1, 0, 0, 0, 0);
        // R8 both violations
        access("R8 both", 1, 32'hF000_0000, 2'b00, 2'b00, 1, 1, 0, 1, 1);
        // R9 idle cycle and pulse width
        access("R9 idle", 0, 32'hF000_0000, 2'b00, 2'b00, 1, 1, 0, 0, 0);
        access("R9 pulse", 1, 32'hF000_0000, 2'b01, 2'b00, 1, 0, 0, 0, 0);
        access("R9 after pulse", 0, 32'h0, 2'b01, 2'b00, 1, 0, 0, 0, 0);

        // Random mix
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] a;
            a = $urandom;
            if ($urandom_range(0, 2) == 0) a[31:28] = 4'(12 + $urandom_range(0, 3));
            access("R1-mix random", ($urandom_range(0, 7) != 0), a,
                   2'($urandom), 2'($urandom), 1'($urandom), 1'($urandom),
                   1'($urandom), 1'($urandom), 1'($urandom));
        end

        // R10 reset clears a pending trap
        @(negedge clk);
        acc_valid = 1; acc_addr = 32'hF000_0000; priv = 2'b00; virt_mode = 1;
        rst_n = 1'b0;
        @(posedge clk); #1;
        check("R10 reset hold trap_region", trap_region, 1'b0);
        check("R10 reset hold trap_page", trap_page, 1'b0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule